// File: doc/BRIEF.md
# Audio Serial Clock Auto-Detector

This block watches the frame-sync and bit-clock lines of an audio serial port. It works from a free-running reference clock and never uses either audio line as a clock. It times the frame period in reference cycles and matches it to one of eighteen standard frame rates. These fall into two families of nine, one based on multiples of 8 kHz and one based on multiples of 7.35 kHz. It also counts bit-clock rising edges per frame to obtain the bit-clock-to-frame ratio. It then decides whether the rate and ratio together form a supported pair. The result goes into a status set that downstream clock logic and host software can read. An unsupported pair, or a frame sync that stops, raises a clock-error interrupt and a mute request for every channel.

The status is updated only after several frames agree, so a glitching clock does not change it. The host has two controls. The first forces the frame-rate code from a host register, which turns off rate measurement. The second silences the error outputs.

A three-state machine controls the measurement:

- `ST_SEEK` waits for the first frame edge and goes to `ST_COLLECT` when it arrives.
- `ST_COLLECT` counts consecutive identical results. It moves to `ST_LOCKED` on the fourth one, and at that point the status and error are loaded.
- `ST_LOCKED` holds its state while results keep matching the held status. It returns to `ST_COLLECT` when a result differs.
- Both `ST_COLLECT` and `ST_LOCKED` fall back to `ST_SEEK` when the frame sync is lost.

Top module: `audio_clk_autodet`

## Requirements
- R1: After reset the rate index and ratio index read 15 (no result), the family bit reads 0, and the interrupt and all mute bits are low.
- R2: A measured frame period within ±2 % of REF_HZ/rate selects that rate. The index runs 0..8 in ascending rate order. The 8 kHz family (8, 16, 24, 32, 48, 96, 192, 384, 768 kHz) has family bit 0, and the 7.35 kHz family (7.35, 14.7, 22.05, 29.4, 44.1, 88.2, 176.4, 352.8, 705.6 kHz) has family bit 1.
- R3: A period outside every window reports rate index 15 with family bit 0, and the result is unsupported.
- R4: A per-frame bit-clock count in the list 16, 24, 32, 48, 64, 96, 128, 192, 256, 384, 512, 1024, 2048 reports its position in that list (0..12). Any other count reports ratio index 15 and is unsupported.
- R5: In family 0 a pair is supported only if rate×ratio is between 256 000 Hz and 24 576 000 Hz inclusive.
- R6: In family 1 a pair is supported only if rate×ratio is between 352 800 Hz and 22 579 200 Hz inclusive.
- R7: An unsupported pair, once locked, raises the interrupt and sets every mute bit.
- R8: Status is loaded, and the error cleared, only when four consecutive measured frames give identical results. Fewer identical frames leave the status and error unchanged.
- R9: While the ignore control is high, the interrupt and the mute bits are low. Status reporting is unaffected.
- R10: With the custom-clock control high, the rate index and family come from the host inputs. A host index above 8 reports 15 and is unsupported. The ratio is still measured.
- R11: If no frame edge arrives for LOSS_US microseconds of reference time, the error is raised and the held status codes remain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock (REF_HZ) |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | Frame sync from the audio port (asynchronous) |
| bclk_i | input | 1 | Bit clock from the audio port (asynchronous) |
| ignore_err_i | input | 1 | Host control: suppress interrupt and mute |
| custom_clk_i | input | 1 | Host control: take rate from host inputs |
| host_rate_fam_i | input | 1 | Host-forced rate family |
| host_rate_idx_i | input | 4 | Host-forced rate index |
| rate_fam_o | output | 1 | Detected rate family |
| rate_idx_o | output | 4 | Detected rate index (15 = none) |
| ratio_idx_o | output | 4 | Detected ratio index (15 = none) |
| clk_err_irq_o | output | 1 | Clock-error interrupt |
| mute_req_o | output | CH_COUNT | Per-channel mute request |

## Verification
The assertions watch the lock sequencing on every cycle. The status register may change only on a `ST_COLLECT` to `ST_LOCKED` step, and the error may fall only on that step. The streak counter never passes four, and a loss timeout always sends the machine to `ST_SEEK`. Every cycle also checks that the rate windows never overlap. Only the bench scenarios can show the classification itself, the family limits on rate×ratio, the ignore and custom controls, and the hold-off during a partial streak. They do this by driving real frame and bit-clock patterns and comparing the settled status against expectations computed in the bench.

// File: rtl/acd_pkg.sv
package acd_pkg;

    localparam int unsigned RATE_CNT  = 9;
    localparam int unsigned RATIO_CNT = 13;
    localparam logic [3:0]  CODE_NONE = 4'hF;

    // Support limits expressed as (multiplier x ratio), per family base rate
    localparam int unsigned PROD_MIN_F0 = 32;   // 256 kHz / 8 kHz
    localparam int unsigned PROD_MIN_F1 = 48;   // 352.8 kHz / 7.35 kHz
    localparam int unsigned PROD_MAX    = 3072; // 24.576 MHz / 8 kHz = 22.5792 MHz / 7.35 kHz

    typedef enum logic [1:0] {
        ST_SEEK,
        ST_COLLECT,
        ST_LOCKED
    } acd_state_e;

    typedef struct packed {
        logic       fam;
        logic [3:0] ridx;
        logic [3:0] qidx;
        logic       sup;
    } acd_result_t;

    function automatic int unsigned rate_mult(input logic [3:0] idx);
        case (idx)
            4'd0:    return 1;
            4'd1:    return 2;
            4'd2:    return 3;
            4'd3:    return 4;
            4'd4:    return 6;
            4'd5:    return 12;
            4'd6:    return 24;
            4'd7:    return 48;
            4'd8:    return 96;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned ratio_val(input logic [3:0] idx);
        case (idx)
            4'd0:    return 16;
            4'd1:    return 24;
            4'd2:    return 32;
            4'd3:    return 48;
            4'd4:    return 64;
            4'd5:    return 96;
            4'd6:    return 128;
            4'd7:    return 192;
            4'd8:    return 256;
            4'd9:    return 384;
            4'd10:   return 512;
            4'd11:   return 1024;
            4'd12:   return 2048;
            default: return 0;
        endcase
    endfunction

    function automatic longint unsigned rate_hz(input logic fam, input logic [3:0] idx);
        longint unsigned base;
        base = fam ? 64'd7350 : 64'd8000;
        return base * longint'(rate_mult(idx));
    endfunction

endpackage

// File: rtl/acd_edge_sync.sv
module acd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/acd_rate_match.sv
module acd_rate_match
    import acd_pkg::*;
#(
    parameter longint unsigned REF_HZ = 49_152_000,
    parameter int unsigned     CW     = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] per_i,
    output logic          hit_o,
    output logic          fam_o,
    output logic [3:0]    idx_o
);
    localparam int RC    = int'(RATE_CNT);
    localparam int SLOTS = 2 * RC;

    logic [SLOTS-1:0] hit;
    logic [63:0]      per_w;

    assign per_w = 64'(per_i);

    for (genvar f = 0; f < 2; f++) begin : g_fam
        for (genvar i = 0; i < RC; i++) begin : g_rate
            localparam longint unsigned DEN = rate_hz(1'(f), 4'(i)) * 64'd50;
            localparam longint unsigned LO  = (REF_HZ * 64'd49 + DEN - 64'd1) / DEN;
            localparam longint unsigned HI  = (REF_HZ * 64'd51) / DEN;
            assign hit[f*RC+i] = (per_w >= LO) && (per_w <= HI);
        end
    end

    always_comb begin
        hit_o = 1'b0;
        fam_o = 1'b0;
        idx_o = CODE_NONE;
        for (int k = 0; k < SLOTS; k++) begin
            if (hit[k] && !hit_o) begin
                hit_o = 1'b1;
                fam_o = (k >= RC);
                idx_o = 4'((k >= RC) ? (k - RC) : k);
            end
        end
    end

    assert_windows_disjoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/acd_ratio_match.sv
module acd_ratio_match
    import acd_pkg::*;
#(
    parameter int unsigned CW = 12
) (
    input  logic [CW-1:0] cnt_i,
    output logic          hit_o,
    output logic [3:0]    idx_o
);
    localparam int QC = int'(RATIO_CNT);

    logic [QC-1:0] eq;
    logic [31:0]   cnt_w;

    assign cnt_w = 32'(cnt_i);

    for (genvar k = 0; k < QC; k++) begin : g_ratio
        assign eq[k] = (cnt_w == ratio_val(4'(k)));
    end

    always_comb begin
        hit_o = 1'b0;
        idx_o = CODE_NONE;
        for (int k = 0; k < QC; k++) begin
            if (eq[k] && !hit_o) begin
                hit_o = 1'b1;
                idx_o = 4'(k);
            end
        end
    end
endmodule

// File: rtl/audio_clk_autodet.sv
module audio_clk_autodet
    import acd_pkg::*;
#(
    parameter longint unsigned REF_HZ   = 49_152_000,
    parameter int unsigned     LOSS_US  = 2000,
    parameter int unsigned     CH_COUNT = 4,
    parameter int unsigned     BCLK_CW  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fsync_i,
    input  logic                bclk_i,
    input  logic                ignore_err_i,
    input  logic                custom_clk_i,
    input  logic                host_rate_fam_i,
    input  logic [3:0]          host_rate_idx_i,
    output logic                rate_fam_o,
    output logic [3:0]          rate_idx_o,
    output logic [3:0]          ratio_idx_o,
    output logic                clk_err_irq_o,
    output logic [CH_COUNT-1:0] mute_req_o
);
    localparam longint unsigned LOSS_CYC = (REF_HZ * longint'(LOSS_US)) / 64'd1_000_000;
    localparam int unsigned     PER_CW   = $clog2(LOSS_CYC + 2);
    localparam logic [2:0]      STREAK   = 3'd4;

    // ---------------- edge detection in the reference domain
    logic fs_rise, bk_rise;

    acd_edge_sync #(.STAGES(2)) u_fs_sync (
        .clk(clk), .rst_n(rst_n), .d_i(fsync_i), .rise_o(fs_rise)
    );
    acd_edge_sync #(.STAGES(2)) u_bk_sync (
        .clk(clk), .rst_n(rst_n), .d_i(bclk_i), .rise_o(bk_rise)
    );

    acd_state_e state_q, state_n;

    // ---------------- frame period and bit-clock counters
    logic [PER_CW-1:0]  per_cnt, smp_per;
    logic [BCLK_CW-1:0] bk_cnt, smp_bk;
    logic               smp_v;
    logic               lost;

    assign lost = (per_cnt == PER_CW'(LOSS_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_cnt <= '0;
            bk_cnt  <= '0;
            smp_per <= '0;
            smp_bk  <= '0;
            smp_v   <= 1'b0;
        end else begin
            smp_v <= fs_rise && (state_q != ST_SEEK);
            if (fs_rise) begin
                smp_per <= per_cnt + 1'b1;
                smp_bk  <= bk_cnt;
                per_cnt <= '0;
                bk_cnt  <= bk_rise ? BCLK_CW'(1) : '0;
            end else begin
                if (!lost)
                    per_cnt <= per_cnt + 1'b1;
                if (bk_rise && (bk_cnt != '1))
                    bk_cnt <= bk_cnt + 1'b1;
            end
        end
    end

    // ---------------- classification
    logic       m_hit, m_fam, q_hit;
    logic [3:0] m_idx, q_idx;

    acd_rate_match #(.REF_HZ(REF_HZ), .CW(PER_CW)) u_rate (
        .clk(clk), .rst_n(rst_n), .per_i(smp_per),
        .hit_o(m_hit), .fam_o(m_fam), .idx_o(m_idx)
    );

    acd_ratio_match #(.CW(BCLK_CW)) u_ratio (
        .cnt_i(smp_bk), .hit_o(q_hit), .idx_o(q_idx)
    );

    acd_result_t cand;
    logic [31:0] prod;
    logic [31:0] prod_min;

    always_comb begin
        if (custom_clk_i) begin
            if (host_rate_idx_i <= 4'd8) begin
                cand.ridx = host_rate_idx_i;
                cand.fam  = host_rate_fam_i;
            end else begin
                cand.ridx = CODE_NONE;
                cand.fam  = 1'b0;
            end
        end else begin
            cand.ridx = m_hit ? m_idx : CODE_NONE;
            cand.fam  = m_hit ? m_fam : 1'b0;
        end
        cand.qidx = q_hit ? q_idx : CODE_NONE;
        prod      = rate_mult(cand.ridx) * ratio_val(cand.qidx);
        prod_min  = cand.fam ? PROD_MIN_F1 : PROD_MIN_F0;
        cand.sup  = (cand.ridx != CODE_NONE) && (cand.qidx != CODE_NONE)
                 && (prod >= prod_min) && (prod <= PROD_MAX);
    end

    // ---------------- streak tracking
    acd_result_t prev_q, lock_q;
    logic [2:0]  run_q;
    logic        err_q;
    logic        same_prev, lock_now;

    assign same_prev = (run_q != 3'd0) && (cand == prev_q);
    assign lock_now  = (state_q == ST_COLLECT) && smp_v && !lost
                    && same_prev && (run_q == STREAK - 3'd1);

    // ---------------- state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEEK;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_SEEK: begin
                if (fs_rise) state_n = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (lost)          state_n = ST_SEEK;
                else if (lock_now) state_n = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (lost)                          state_n = ST_SEEK;
                else if (smp_v && (cand != lock_q)) state_n = ST_COLLECT;
            end
            default: state_n = ST_SEEK;
        endcase
    end

    // ---------------- outputs and held status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{fam: 1'b0, ridx: CODE_NONE, qidx: CODE_NONE, sup: 1'b0};
            lock_q <= '{fam: 1'b0, ridx: CODE_NONE, qidx: CODE_NONE, sup: 1'b0};
            run_q  <= 3'd0;
            err_q  <= 1'b0;
        end else if (lost) begin
            run_q <= 3'd0;
            err_q <= 1'b1;
        end else if (smp_v) begin
            prev_q <= cand;
            if (same_prev) begin
                if (run_q < STREAK) run_q <= run_q + 3'd1;
            end else begin
                run_q <= 3'd1;
            end
            if (lock_now) begin
                lock_q <= cand;
                err_q  <= !cand.sup;
            end
        end
    end

    always_comb begin
        rate_fam_o    = lock_q.fam;
        rate_idx_o    = lock_q.ridx;
        ratio_idx_o   = lock_q.qidx;
        clk_err_irq_o = err_q & ~ignore_err_i;
        mute_req_o    = {CH_COUNT{clk_err_irq_o}};
    end

    // ---------------- assertions
    assert_status_on_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != $past(lock_q)) |-> ($past(state_q) == ST_COLLECT && state_q == ST_LOCKED));

    assert_err_clear_on_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_q) |-> ($past(state_q) == ST_COLLECT && state_q == ST_LOCKED));

    assert_streak_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= STREAK);

    assert_loss_to_seek_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !fs_rise) |=> (state_q == ST_SEEK && err_q));

    assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !smp_v) |=> $stable(lock_q));
endmodule

// File: tb/audio_clk_autodet_tb_top.sv
module audio_clk_autodet_tb_top;
    localparam int CH = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, fsync, bclk, ign, cust, hfam;
    logic [3:0]    hidx;
    logic          rate_fam;
    logic [3:0]    rate_idx, ratio_idx;
    logic          irq;
    logic [CH-1:0] mute;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    audio_clk_autodet #(.LOSS_US(200), .CH_COUNT(CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .bclk_i(bclk),
        .ignore_err_i(ign), .custom_clk_i(cust),
        .host_rate_fam_i(hfam), .host_rate_idx_i(hidx),
        .rate_fam_o(rate_fam), .rate_idx_o(rate_idx), .ratio_idx_o(ratio_idx),
        .clk_err_irq_o(irq), .mute_req_o(mute)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic status(input string tag, input int fam, input int ridx,
                          input int qidx, input int eirq);
        chk({tag, " family"}, int'(rate_fam), fam);
        chk({tag, " rate index"}, int'(rate_idx), ridx);
        chk({tag, " ratio index"}, int'(ratio_idx), qidx);
        chk({tag, " irq"}, int'(irq), eirq);
    endtask

    // p reference cycles per frame, n bit clocks per frame, k frames
    task automatic frames(input int p, input int n, input int k);
        for (int f = 0; f < k; f++) begin
            for (int c = 0; c < p; c++) begin
                @(posedge clk);
                #1;
                fsync = (c < p / 2);
                bclk  = (((c * 2 * n) / p) % 2) == 1;
            end
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    // per-cycle model: mute mirrors the interrupt, and ignore keeps both quiet
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk("R7 mute bits follow irq", int'(mute), irq ? (1 << CH) - 1 : 0);
            if (ign) chk("R9 ignore keeps irq low", int'(irq), 0);
        end
    end

    initial begin
        rst_n = 1'b0; fsync = 1'b0; bclk = 1'b0;
        ign = 1'b0; cust = 1'b0; hfam = 1'b0; hidx = 4'd0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        status("R1 reset", 0, 15, 15, 0);
        chk("R1 reset mute", int'(mute), 0);

        // R2: 48 kHz, ratio 64
        frames(1024, 64, 7); settle();
        status("R2 48k x64", 0, 4, 4, 0);

        // R8: three frames of a new pattern must not change status
        frames(1115, 256, 3); settle();
        status("R8 partial streak holds", 0, 4, 4, 0);
        frames(1115, 256, 6); settle();
        status("R8 R2 44.1k x256", 1, 4, 8, 0);

        // R5 upper bound: 768 kHz x32 = 24.576 MHz
        frames(64, 32, 7); settle();
        status("R5 768k x32", 0, 8, 2, 0);

        // R6 upper bound: 705.6 kHz x32 = 22.5792 MHz
        frames(70, 32, 7); settle();
        status("R6 705.6k x32", 1, 8, 2, 0);

        // R5 lower bound: 8 kHz x32 = 256 kHz
        frames(6144, 32, 6); settle();
        status("R5 8k x32", 0, 0, 2, 0);

        // R6 below limit: 14.7 kHz x16 = 235.2 kHz, unsupported
        frames(3344, 16, 6); settle();
        status("R6 R7 14.7k x16", 1, 1, 0, 1);
        chk("R7 all channels muted", int'(mute), (1 << CH) - 1);

        // R9 ignore
        @(posedge clk); #1 ign = 1'b1;
        @(negedge clk);
        chk("R9 ignore irq", int'(irq), 0);
        chk("R9 ignore mute", int'(mute), 0);
        chk("R9 status kept", int'(rate_idx), 1);
        @(posedge clk); #1 ign = 1'b0;
        @(negedge clk);
        chk("R9 release irq", int'(irq), 1);

        // R4 unknown ratio
        frames(1024, 100, 7); settle();
        status("R4 ratio 100", 0, 4, 15, 1);

        // R3 unknown rate
        frames(900, 64, 7); settle();
        status("R3 period 900", 0, 15, 4, 1);

        // R8 error clears on a supported lock
        frames(1024, 64, 7); settle();
        status("R8 relock clears", 0, 4, 4, 0);

        // R10 custom rate from host
        @(posedge clk); #1 cust = 1'b1; hfam = 1'b0; hidx = 4'd4;
        frames(1115, 256, 7); settle();
        status("R10 host 48k x256", 0, 4, 8, 0);
        @(posedge clk); #1 hidx = 4'd9;
        frames(1115, 256, 7); settle();
        status("R10 host index 9", 0, 15, 8, 1);
        @(posedge clk); #1 cust = 1'b0;

        // R11 loss of frame sync
        frames(1024, 64, 7); settle();
        status("R11 pre-loss lock", 0, 4, 4, 0);
        repeat (7000) @(posedge clk);
        @(negedge clk);
        chk("R11 no error before limit", int'(irq), 0);
        repeat (2500) @(posedge clk);
        @(negedge clk);
        chk("R11 error after loss", int'(irq), 1);
        chk("R11 rate held", int'(rate_idx), 4);
        chk("R11 ratio held", int'(ratio_idx), 4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule